// File: doc/BRIEF.md
# Modem Handshake Delay Timer

This block provides the timing side of a low-speed frequency-shift-keyed modem's terminal handshake. A request to transmit (active low) is granted by an active-low clear-to-send only after a hold-off interval. A raw, unfiltered carrier-present flag is turned into a qualified carrier-detect output, using one interval for turning on and a shorter one for turning off. A prescaler divides the master clock into a slow tick. The tick paces every internal delay, and it also leaves the block on a pin so that board-level counters can build custom delays.

The delays are counted in whole tick periods. One 2-bit option code, together with a standard-select bit (V.21 or Bell 103), picks all three intervals at once. They cannot be set one by one. The option code 11 turns all internal timing off. Clear-to-send then copies an externally delayed request input, and carrier-detect copies an externally delayed detect input. An input that changes back before its interval runs out is forgotten, and its count starts again from zero.

Top module: `mdm_hs_timer`

## Requirements
- R1: `tick_o` is a square wave with a period of DIV clock cycles. It is low for the first DIV/2 cycles of each period and high for the last DIV/2. Its falling edge marks a tick boundary, and all internal delay counters advance at that edge. With the default DIV of 4096 and a 3.579545 MHz clock, this gives 873.9 Hz.
- R2: With `std_bell`=0 and `opt_sel` 00, 01 or 10, the fall of `cts_n` happens 350, 26 or 306 tick boundaries after `rts_n` falls. This holds when `rts_n` falls right after a boundary and stays low, and it equals a delay of exactly N*DIV cycles.
- R3: With `std_bell`=1, the request-to-clear delay is 175 ticks, the carrier-on delay is 96 ticks and the carrier-off delay is 26 ticks. The option codes 01 and 10 behave the same as 00.
- R4: In internal modes, `cts_n` rises on the first clock edge after `rts_n` is sampled high, with no tick delay.
- R5: With `std_bell`=0, `cd_o` rises 271, 11 or 140 tick boundaries after `cd_raw` rises, for `opt_sel` 00, 01 or 10 respectively.
- R6: With `std_bell`=0, `cd_o` falls 39 tick boundaries after `cd_raw` falls for options 00 and 01, and 22 tick boundaries after for option 10.
- R7: If a request or carrier input returns to its previous level before its delay expires, the output does not change. A later change must then wait the full delay again.
- R8: With `opt_sel`=11, `cts_n` equals `ext_cts_n` and `cd_o` equals `ext_cd` in the same cycle, and `rts_n` and `cd_raw` have no effect on either output.
- R9: While `rst_n` is low, `cts_n` is high, `cd_o` is low and `tick_o` is low. This assumes an internal option code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rts_n | input | 1 | Request to send, active low, synchronous to clk |
| cd_raw | input | 1 | Unqualified carrier-present flag, high = carrier |
| opt_sel | input | 2 | Delay option code, 11 = external delays |
| std_bell | input | 1 | 1 = Bell 103 timing, 0 = V.21 timing |
| ext_cts_n | input | 1 | Externally delayed clear-to-send, used with option 11 |
| ext_cd | input | 1 | Externally delayed carrier-detect, used with option 11 |
| cts_n | output | 1 | Clear to send, active low |
| cd_o | output | 1 | Qualified carrier detect, high = carrier |
| tick_o | output | 1 | Timing tick square wave, period DIV cycles |

## Verification
The bench builds the block with DIV=4 and keeps the tick counts at their defaults. A 350-tick delay therefore lasts 1400 cycles. This lets every combination of standard and option code be swept, with each delay checked to the exact cycle. The bench aligns to a tick boundary before it changes an input, so the expected latency is exactly N*DIV cycles. It computes N itself by rounding the midpoint of each millisecond window to whole 873.9 Hz periods. The glitch cases use N-1 ticks, the largest interval that must still be filtered out.

// File: rtl/mdm_hs_pkg.sv
// Package: shared types and delay lengths for the modem handshake timer.
// All lengths are whole tick periods of the prescaled timing tick.
package mdm_hs_pkg;

    localparam int LEN_W = 9;

    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [1:0] {
        OPT_LONG   = 2'b00,
        OPT_SHORT  = 2'b01,
        OPT_MID    = 2'b10,
        OPT_EXTERN = 2'b11
    } opt_e;

    typedef struct packed {
        len_t rts_on;
        len_t cd_on;
        len_t cd_off;
    } dly_set_t;

    // V.21 lengths, rounded to the nearest 873.9 Hz period
    localparam len_t V21_RTS_LONG  = len_t'(350);
    localparam len_t V21_RTS_SHORT = len_t'(26);
    localparam len_t V21_RTS_MID   = len_t'(306);
    localparam len_t V21_CDON_LONG  = len_t'(271);
    localparam len_t V21_CDON_SHORT = len_t'(11);
    localparam len_t V21_CDON_MID   = len_t'(140);
    localparam len_t V21_CDOFF_WIDE = len_t'(39);
    localparam len_t V21_CDOFF_MID  = len_t'(22);

    // Bell 103 lengths, one set for every internal option
    localparam len_t B103_RTS   = len_t'(175);
    localparam len_t B103_CDON  = len_t'(96);
    localparam len_t B103_CDOFF = len_t'(26);

endpackage

// File: rtl/mdm_hs_prescale.sv
// Prescaler: divides the master clock by DIV. It gives a one-cycle strobe in the
// last cycle of each period and a square-wave tick whose falling edge lines up
// with the strobe edge.
// Assumes DIV is a power of two, at least 2.
module mdm_hs_prescale #(
    parameter int DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_o,
    output logic tick_o
);
    localparam int PRE_W = $clog2(DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    // Free-running period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign strobe_o = (pre_q == PRE_LAST);
    assign tick_o   = pre_q[PRE_W-1];

endmodule

// File: rtl/mdm_hs_delay_sel.sv
// Delay selector: turns the standard bit and the option code into one set of
// three delay lengths, plus a flag for the external-delay mode.
// Reserved Bell 103 codes fall back to the single Bell set.
module mdm_hs_delay_sel
    import mdm_hs_pkg::*;
(
    input  logic       std_bell,
    input  logic [1:0] opt_sel,
    output dly_set_t   set_o,
    output logic       ext_mode_o
);
    opt_e opt;

    assign opt        = opt_e'(opt_sel);
    assign ext_mode_o = (opt == OPT_EXTERN);

    // Table lookup of the three lengths
    always_comb begin
        if (std_bell) begin
            set_o = '{rts_on: B103_RTS, cd_on: B103_CDON, cd_off: B103_CDOFF};
        end else begin
            unique case (opt)
                OPT_SHORT: set_o = '{rts_on: V21_RTS_SHORT, cd_on: V21_CDON_SHORT,
                                     cd_off: V21_CDOFF_WIDE};
                OPT_MID:   set_o = '{rts_on: V21_RTS_MID, cd_on: V21_CDON_MID,
                                     cd_off: V21_CDOFF_MID};
                default:   set_o = '{rts_on: V21_RTS_LONG, cd_on: V21_CDON_LONG,
                                     cd_off: V21_CDOFF_WIDE};
            endcase
        end
    end

endmodule

// File: rtl/mdm_hs_qualify.sv
// Qualifier: the output takes on a new input level only after the input has held
// that level for on_len (rising) or off_len (falling) strobes in a row. A length
// of zero means the output follows on the next clock. A return of the input to
// the output level clears the count. When en is low, the output is held low and
// the count is held at zero.
module mdm_hs_qualify #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic             raw,
    input  logic [LEN_W-1:0] on_len,
    input  logic [LEN_W-1:0] off_len,
    output logic             q_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] target;
    logic [LEN_W:0]   cnt_inc;
    logic             expire;

    // Length for the pending transition
    assign target  = raw ? on_len : off_len;
    assign cnt_inc = {1'b0, cnt_q} + {{LEN_W{1'b0}}, 1'b1};
    assign expire  = (cnt_inc >= {1'b0, target});

    // Count strobes while the input differs from the output
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            q_o   <= 1'b0;
            cnt_q <= '0;
        end else if (raw == q_o) begin
            cnt_q <= '0;
        end else if (target == '0) begin
            q_o   <= raw;
            cnt_q <= '0;
        end else if (strobe) begin
            if (expire) begin
                q_o   <= raw;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc[LEN_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mdm_hs_timer.sv
// Top: modem handshake delay timer. It delays the request-to-clear handshake,
// qualifies the raw carrier flag, and exports the timing tick.
// Assumes rts_n, cd_raw and the external inputs are synchronous to clk.
module mdm_hs_timer
    import mdm_hs_pkg::*;
#(
    parameter int DIV = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rts_n,
    input  logic       cd_raw,
    input  logic [1:0] opt_sel,
    input  logic       std_bell,
    input  logic       ext_cts_n,
    input  logic       ext_cd,
    output logic       cts_n,
    output logic       cd_o,
    output logic       tick_o
);
    logic     strobe;
    logic     ext_mode;
    dly_set_t dly;
    logic     rts_q;
    logic     cd_q;

    mdm_hs_prescale #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_o (strobe),
        .tick_o   (tick_o)
    );

    mdm_hs_delay_sel u_sel (
        .std_bell   (std_bell),
        .opt_sel    (opt_sel),
        .set_o      (dly),
        .ext_mode_o (ext_mode)
    );

    // Request path: delayed turn-on, immediate turn-off
    mdm_hs_qualify #(.LEN_W(LEN_W)) u_rts_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!ext_mode),
        .strobe  (strobe),
        .raw     (!rts_n),
        .on_len  (dly.rts_on),
        .off_len ('0),
        .q_o     (rts_q)
    );

    // Carrier path: asymmetric on and off qualification
    mdm_hs_qualify #(.LEN_W(LEN_W)) u_cd_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!ext_mode),
        .strobe  (strobe),
        .raw     (cd_raw),
        .on_len  (dly.cd_on),
        .off_len (dly.cd_off),
        .q_o     (cd_q)
    );

    assign cts_n = ext_mode ? ext_cts_n : !rts_q;
    assign cd_o  = ext_mode ? ext_cd    : cd_q;

endmodule

// File: rtl/mdm_hs_timer_chk.sv
// Checker: timing properties of the handshake timer, bound to every instance.
module mdm_hs_timer_chk #(
    parameter int DIV = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rts_n,
    input logic [1:0] opt_sel,
    input logic       ext_cts_n,
    input logic       ext_cd,
    input logic       cts_n,
    input logic       cd_o,
    input logic       tick_o
);
    localparam int RUN_W = $clog2(DIV) + 1;
    localparam logic [RUN_W-1:0] HALF = RUN_W'(DIV / 2);

    logic [RUN_W-1:0] run_q;
    logic             tick_d;
    logic             ext;

    assign ext = (opt_sel == 2'b11);

    // Length of the current tick level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            tick_d <= 1'b0;
        end else begin
            tick_d <= tick_o;
            run_q  <= (tick_o != tick_d) ? RUN_W'(1) : run_q + RUN_W'(1);
        end
    end

    AST_TICK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o != tick_d) |-> (run_q == HALF));   // R1
    AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= HALF);   // R1
    AST_CTS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext && $past(!ext) && $fell(cts_n)) |-> $fell(tick_o));   // R2
    AST_CTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext && rts_n) |=> (cts_n || ext));   // R4
    AST_CD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext && $past(!ext) && (cd_o != $past(cd_o))) |-> $fell(tick_o));   // R5
    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ext |-> (cts_n == ext_cts_n && cd_o == ext_cd));   // R8

endmodule

bind mdm_hs_timer mdm_hs_timer_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rts_n     (rts_n),
    .opt_sel   (opt_sel),
    .ext_cts_n (ext_cts_n),
    .ext_cd    (ext_cd),
    .cts_n     (cts_n),
    .cd_o      (cd_o),
    .tick_o    (tick_o)
);

// File: tb/mdm_hs_timer_bench.sv
module mdm_hs_timer_bench;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rts_n = 1'b1;
    logic       cd_raw = 1'b0;
    logic [1:0] opt_sel = 2'b00;
    logic       std_bell = 1'b0;
    logic       ext_cts_n = 1'b1;
    logic       ext_cd = 1'b0;
    logic       cts_n;
    logic       cd_o;
    logic       tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mdm_hs_timer #(.DIV(DIV)) u_mdm_hs_timer (
        .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .cd_raw(cd_raw),
        .opt_sel(opt_sel), .std_bell(std_bell), .ext_cts_n(ext_cts_n),
        .ext_cd(ext_cd), .cts_n(cts_n), .cd_o(cd_o), .tick_o(tick_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Ticks = nearest whole 873.9 Hz period to a delay given in tenths of ms
    function automatic int to_ticks(input int tenth_ms);
        longint num;
        num = longint'(tenth_ms) * 64'd3579545 + 64'd20480000;
        return int'(num / 64'd40960000);
    endfunction

    // Wait for the negedge just after a tick boundary edge
    task automatic wait_bound();
        logic last;
        bit   hit;
        last = tick_o;
        hit  = 0;
        while (!hit) begin
            @(negedge clk);
            if (last && !tick_o) hit = 1;
            last = tick_o;
        end
    endtask

    // Count negedges until the chosen output leaves its start level
    task automatic meas(input bit use_cts, input logic start, output int n);
        logic v;
        n = 0;
        v = start;
        while (v == start && n < 3000) begin
            @(negedge clk);
            n++;
            v = use_cts ? cts_n : cd_o;
        end
    endtask

    task automatic run_internal(input bit bell, input logic [1:0] opt);
        int rts_t, on_t, off_t, n;
        string tg;
        std_bell = bell;
        opt_sel  = opt;
        rts_n    = 1'b1;
        cd_raw   = 1'b0;
        repeat (60 * DIV) @(negedge clk);
        if (bell) begin
            rts_t = to_ticks(2000); on_t = to_ticks(1100); off_t = to_ticks(300);
            tg = (opt == 2'b00) ? "R3" : "R3_reserved";
        end else begin
            rts_t = (opt == 2'b00) ? to_ticks(4000) : (opt == 2'b01) ? to_ticks(300) : to_ticks(3500);
            on_t  = (opt == 2'b00) ? to_ticks(3100) : (opt == 2'b01) ? to_ticks(125) : to_ticks(1600);
            off_t = (opt == 2'b10) ? to_ticks(250) : to_ticks(450);
            tg = "R2";
        end
        // R2 / R3: request to clear delay
        wait_bound(); rts_n = 1'b0;
        meas(1'b1, 1'b1, n);
        chk(bell ? tg : "R2", n, rts_t * DIV);
        // R4: immediate release
        rts_n = 1'b1; @(negedge clk);
        chk("R4", int'(cts_n), 1);
        // R5: carrier on delay
        wait_bound(); cd_raw = 1'b1;
        meas(1'b0, 1'b0, n);
        chk(bell ? tg : "R5", n, on_t * DIV);
        // R6: carrier off delay
        wait_bound(); cd_raw = 1'b0;
        meas(1'b0, 1'b1, n);
        chk(bell ? tg : "R6", n, off_t * DIV);
        // R7: request glitch one tick short of expiry
        wait_bound(); rts_n = 1'b0;
        repeat ((rts_t - 1) * DIV) @(negedge clk);
        chk("R7_rts_short", int'(cts_n), 1);
        rts_n = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        chk("R7_rts_after", int'(cts_n), 1);
        wait_bound(); rts_n = 1'b0;
        meas(1'b1, 1'b1, n);
        chk("R7_rts_restart", n, rts_t * DIV);
        rts_n = 1'b1; @(negedge clk);
        // R7: carrier glitch on both edges
        wait_bound(); cd_raw = 1'b1;
        repeat ((on_t - 1) * DIV) @(negedge clk);
        chk("R7_cd_short", int'(cd_o), 0);
        cd_raw = 1'b0;
        repeat (2 * DIV) @(negedge clk);
        chk("R7_cd_after", int'(cd_o), 0);
        cd_raw = 1'b1;
        repeat ((on_t + 2) * DIV) @(negedge clk);
        wait_bound(); cd_raw = 1'b0;
        repeat ((off_t - 1) * DIV) @(negedge clk);
        chk("R7_cd_drop_short", int'(cd_o), 1);
        cd_raw = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        chk("R7_cd_drop_after", int'(cd_o), 1);
        cd_raw = 1'b0;
    endtask

    initial begin
        int n, hi;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9_cts", int'(cts_n), 1);
        chk("R9_cd", int'(cd_o), 0);
        chk("R9_tick", int'(tick_o), 0);
        rst_n = 1'b1;
        // R1: tick period and duty
        wait_bound();
        n = 0; hi = 0;
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk);
            n++;
            if (tick_o) hi++;
        end
        chk("R1_high", hi, DIV / 2);
        chk("R1_end", int'(tick_o), 0);
        wait_bound();
        // R2, R3, R5, R6, R7 sweep
        for (int b = 0; b < 2; b++) begin
            for (int o = 0; o < 3; o++) begin
                run_internal(b[0], o[1:0]);
            end
        end
        // R8: external delays
        for (int b = 0; b < 2; b++) begin
            std_bell = b[0];
            opt_sel = 2'b11;
            ext_cts_n = 1'b1; ext_cd = 1'b0;
            @(negedge clk);
            rts_n = 1'b0; cd_raw = 1'b1;
            repeat (400 * DIV) @(negedge clk);
            chk("R8_ignore_cts", int'(cts_n), 1);
            chk("R8_ignore_cd", int'(cd_o), 0);
            ext_cts_n = 1'b0; ext_cd = 1'b1; #1;
            chk("R8_follow_cts", int'(cts_n), 0);
            chk("R8_follow_cd", int'(cd_o), 1);
            @(negedge clk);
            ext_cts_n = 1'b1; ext_cd = 1'b0; #1;
            chk("R8_back_cts", int'(cts_n), 1);
            chk("R8_back_cd", int'(cd_o), 0);
            rts_n = 1'b1; cd_raw = 1'b0;
            @(negedge clk);
        end
        // Leaving external mode restarts from idle
        opt_sel = 2'b00; std_bell = 1'b0;
        @(negedge clk);
        chk("R8_exit_cts", int'(cts_n), 1);
        chk("R8_exit_cd", int'(cd_o), 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule